// File: doc/BRIEF.md
# ATA Task-File Command Sequencer

This block is the device-side sequencer of a parallel ATA register interface. The host uses a simple synchronous register port. It selects the command block (offsets 0 to 7) or the control block (offset 6 only) and writes task-file bytes or a command opcode. It reads status, error, task-file contents and 16-bit data words. The sequencer takes a command only when it is quiet. While a command runs it drives the busy, data-request and error status bits and the interrupt line.

Two data-in commands are supported: a sector-at-a-time read and a blocked read. The blocked read uses the block size chosen by a set-block-size command. Two no-data commands are supported: the block-size setting and a self-diagnostic. The diagnostic is also the one command that can break into a running transfer. A request/ready pair stands in for the media. The device asks for each sector and waits for a one-cycle ready pulse. Each sector then yields a fixed number of words whose values follow a simple pattern, so a host can tell where every word came from.

Top module: `ata_taskfile_seq`

## Requirements
- R1: After reset the status byte reads 50h (ready and seek-complete set, busy, data-request and error clear), the error register reads 01h, and the interrupt pin is low.
- R2: A command accepted while idle shows busy (status D0h) from the next cycle. While the media has not answered, busy stays set and the sector request output stays high.
- R3: A read of the status register (command block offset 7) clears a pending interrupt.
- R4: The alternate status register (control block offset 6) returns the same byte as status and leaves the interrupt pending.
- R5: Read-sectors (20h) fetches each sector with busy set. It then presents status 58h and raises the interrupt. Word w of the k-th sector, counted from 0, reads as {(sector-number register + k) mod 256, w mod 256} from offset 0. Each sector holds 256 words.
- R6: After the last word of the last sector, status reads 50h and no interrupt is raised.
- R7: Set-block-size (C6h) accepts a sector count that is a power of two no larger than 16. It completes with status 50h, error 00h and an interrupt. Any other count aborts and leaves the previous block size in place.
- R8: Read-blocked (C4h) moves min(block size, sectors left) sectors per block. It raises one interrupt per block, and data-request stays set across every sector of the block.
- R9: Read-blocked issued while no block size has been set since reset aborts.
- R10: An unsupported opcode aborts: error register 04h, status 51h, interrupt raised.
- R11: Diagnostic (90h) completes with error 01h, status 50h and an interrupt. It is accepted even during a running transfer, which it ends.
- R12: While busy or data-request is set, any other command write is ignored and the transfer continues unchanged. Writes to the sector-count register are also ignored at that time.
- R13: Bit 1 of a control-block write to offset 6 masks the interrupt pin. The pending interrupt survives the mask and appears when the mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects happen at the clock edge) |
| host_ctl | input | 1 | 1 selects the control block, 0 the command block |
| host_reg | input | 3 | Register offset within the selected block |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 16 | Read data for the addressed register |
| intrq | output | 1 | Interrupt request to the host |
| sec_req | output | 1 | Sequencer is waiting for a sector from the media |
| sec_rdy | input | 1 | One-cycle pulse: one requested sector is ready |

## Verification
The assertions cover what is visible on every cycle. An accepted command must show busy next. Busy and data-request must never be set together. A status read must drop the pending interrupt and an alternate read must keep it. A non-diagnostic write during a transfer must leave the word position alone, and a busy sector-count write must not land. The block length must stay within bounds. Only the bench can show the end-to-end behaviour: the data pattern across whole blocks, one interrupt per block with silence in between, a quiet end after the final word, a block size that survives a rejected setting, and the masked interrupt coming back when the mask is lifted.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

  localparam logic [7:0] OP_READ_SECT = 8'h20;
  localparam logic [7:0] OP_READ_MULT = 8'hC4;
  localparam logic [7:0] OP_SET_MULT  = 8'hC6;
  localparam logic [7:0] OP_DIAG      = 8'h90;

  localparam logic [7:0] ERR_ABORT = 8'h04;
  localparam logic [7:0] DIAG_PASS = 8'h01;

  localparam logic [2:0] REG_DATA = 3'd0;
  localparam logic [2:0] REG_ERR  = 3'd1;
  localparam logic [2:0] REG_SCNT = 3'd2;
  localparam logic [2:0] REG_SNUM = 3'd3;
  localparam logic [2:0] REG_CYLL = 3'd4;
  localparam logic [2:0] REG_CYLH = 3'd5;
  localparam logic [2:0] REG_DEVH = 3'd6;
  localparam logic [2:0] REG_CMD  = 3'd7;
  localparam logic [2:0] REG_ALT  = 3'd6;

  typedef enum logic [1:0] {SQ_IDLE, SQ_EXEC, SQ_FETCH, SQ_XFER} sq_state_t;

  // Data word for sector ordinal 'ord' of a command whose start register is 'base'.
  function automatic logic [15:0] word_pattern(logic [7:0] base, logic [7:0] ord,
                                               logic [15:0] idx);
    logic [7:0] hi;
    hi = base + ord;
    return {hi ^ idx[15:8], idx[7:0]};
  endfunction

  // Sectors in the next block: the smaller of block size and sectors left.
  function automatic logic [8:0] block_len(logic [8:0] per_blk, logic [8:0] left);
    return (left < per_blk) ? left : per_blk;
  endfunction

  // Block size must be a nonzero power of two not above the limit.
  function automatic logic mult_ok(logic [7:0] n, logic [8:0] max_n);
    return (n != 8'd0) && ({1'b0, n} <= max_n) && ((n & (n - 8'd1)) == 8'd0);
  endfunction

  function automatic logic [7:0] status_byte(logic bsy, logic drq, logic err);
    return {bsy, 1'b1, 1'b0, 1'b1, drq, 1'b0, 1'b0, err};
  endfunction

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_ctl,
  input  logic [2:0] host_reg,
  input  logic [7:0] host_wdata,
  input  logic       busy,
  output logic [7:0] scnt_q,
  output logic [7:0] snum_q,
  output logic [7:0] cyll_q,
  output logic [7:0] cylh_q,
  output logic [7:0] devh_q,
  output logic       nien_q,
  output logic       cmd_wr,
  output logic [7:0] cmd_code
);

  logic tf_wr;
  logic ctl_wr;

  assign tf_wr    = host_wr && !host_ctl && !busy;
  assign ctl_wr   = host_wr && host_ctl && (host_reg == REG_ALT);
  assign cmd_wr   = host_wr && !host_ctl && (host_reg == REG_CMD);
  assign cmd_code = host_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt_q <= 8'd1;
      snum_q <= 8'd1;
      cyll_q <= 8'd0;
      cylh_q <= 8'd0;
      devh_q <= 8'd0;
      nien_q <= 1'b0;
    end else begin
      if (tf_wr) begin
        case (host_reg)
          REG_SCNT: scnt_q <= host_wdata;
          REG_SNUM: snum_q <= host_wdata;
          REG_CYLL: cyll_q <= host_wdata;
          REG_CYLH: cylh_q <= host_wdata;
          REG_DEVH: devh_q <= host_wdata;
          default:  ;
        endcase
      end
      if (ctl_wr) nien_q <= host_wdata[1];
    end
  end

  // R12: a sector-count write while busy must not land
  assert_tf_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr && !host_ctl && host_reg == REG_SCNT) |=> $stable(scnt_q));

endmodule

// File: rtl/ata_seq_fsm.sv
module ata_seq_fsm
  import ata_seq_pkg::*;
#(
  parameter int WORDS_PER_SECTOR = 256,
  parameter int MAX_MULT         = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_code,
  input  logic [7:0] scnt,
  input  logic       sec_rdy,
  input  logic       data_rd,
  output logic       bsy,
  output logic       drq,
  output logic       err_flag,
  output logic [7:0] err_reg,
  output logic       sec_req,
  output logic       irq_set,
  output logic       cmd_accept,
  output logic [7:0] sec_ord,
  output logic [$clog2(WORDS_PER_SECTOR)-1:0] word_idx
);

  localparam int             IDX_W     = $clog2(WORDS_PER_SECTOR);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(WORDS_PER_SECTOR - 1);
  localparam logic [8:0]     MAX_M     = 9'(MAX_MULT);

  sq_state_t  state;
  logic [7:0] cmd_q;
  logic [8:0] remain, blk, fetched, sec_in_blk, mult_q;
  logic       multi_mode;

  // named internal events
  logic [8:0] scnt_n, remain_after, blk_last;
  logic       sec_taken, blk_ready, word_take, sect_done, blk_done, cmd_finish;
  logic       exec_to_fetch, exec_state;

  assign scnt_n        = (scnt == 8'd0) ? 9'd256 : {1'b0, scnt};
  assign remain_after  = remain - blk;
  assign blk_last      = blk - 9'd1;
  assign exec_state    = (state == SQ_EXEC);
  assign cmd_accept    = cmd_wr && ((state == SQ_IDLE) || (cmd_code == OP_DIAG));
  assign sec_taken     = (state == SQ_FETCH) && sec_rdy;
  assign blk_ready     = sec_taken && (fetched == blk_last);
  assign word_take     = (state == SQ_XFER) && data_rd;
  assign sect_done     = word_take && (word_idx == LAST_WORD);
  assign blk_done      = sect_done && (sec_in_blk == blk_last);
  assign cmd_finish    = blk_done && (remain == blk);
  assign exec_to_fetch = (cmd_q == OP_READ_SECT) ||
                         ((cmd_q == OP_READ_MULT) && (mult_q != 9'd0));
  assign irq_set       = !cmd_accept && ((exec_state && !exec_to_fetch) || blk_ready);

  assign bsy     = (state == SQ_EXEC) || (state == SQ_FETCH);
  assign drq     = (state == SQ_XFER);
  assign sec_req = (state == SQ_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      cmd_q      <= 8'd0;
      remain     <= 9'd0;
      blk        <= 9'd1;
      fetched    <= 9'd0;
      sec_in_blk <= 9'd0;
      mult_q     <= 9'd0;
      multi_mode <= 1'b0;
      err_reg    <= DIAG_PASS;
      err_flag   <= 1'b0;
      sec_ord    <= 8'd0;
      word_idx   <= '0;
    end else if (cmd_accept) begin
      state      <= SQ_EXEC;
      cmd_q      <= cmd_code;
      err_reg    <= 8'd0;
      err_flag   <= 1'b0;
      sec_ord    <= 8'd0;
      word_idx   <= '0;
      fetched    <= 9'd0;
      sec_in_blk <= 9'd0;
    end else begin
      case (state)
        SQ_EXEC: begin
          state <= SQ_IDLE;
          case (cmd_q)
            OP_DIAG: err_reg <= DIAG_PASS;
            OP_SET_MULT: begin
              if (mult_ok(scnt, MAX_M)) begin
                mult_q <= {1'b0, scnt};
              end else begin
                err_reg  <= ERR_ABORT;
                err_flag <= 1'b1;
              end
            end
            OP_READ_SECT: begin
              multi_mode <= 1'b0;
              remain     <= scnt_n;
              blk        <= 9'd1;
              state      <= SQ_FETCH;
            end
            OP_READ_MULT: begin
              if (mult_q == 9'd0) begin
                err_reg  <= ERR_ABORT;
                err_flag <= 1'b1;
              end else begin
                multi_mode <= 1'b1;
                remain     <= scnt_n;
                blk        <= block_len(mult_q, scnt_n);
                state      <= SQ_FETCH;
              end
            end
            default: begin
              err_reg  <= ERR_ABORT;
              err_flag <= 1'b1;
            end
          endcase
        end
        SQ_FETCH: begin
          if (blk_ready) begin
            fetched    <= 9'd0;
            sec_in_blk <= 9'd0;
            word_idx   <= '0;
            state      <= SQ_XFER;
          end else if (sec_taken) begin
            fetched <= fetched + 9'd1;
          end
        end
        SQ_XFER: begin
          if (sect_done) begin
            word_idx <= '0;
            sec_ord  <= sec_ord + 8'd1;
            if (blk_done) begin
              remain     <= remain_after;
              sec_in_blk <= 9'd0;
              if (cmd_finish) begin
                state <= SQ_IDLE;
              end else begin
                blk   <= block_len(multi_mode ? mult_q : 9'd1, remain_after);
                state <= SQ_FETCH;
              end
            end else begin
              sec_in_blk <= sec_in_blk + 9'd1;
            end
          end else if (word_take) begin
            word_idx <= word_idx + IDX_W'(1);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R2: an accepted command shows busy on the next cycle
  assert_bsy_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> bsy);

  // R5: busy and data-request never together
  assert_bsy_drq_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy && drq));

  // R12: a non-diagnostic command during transfer leaves the transfer alone
  assert_drq_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && cmd_wr && cmd_code != OP_DIAG && !data_rd) |=> (drq && $stable(word_idx)));

  // R8: block length stays within 1..MAX_MULT while a transfer runs
  assert_blk_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_req || drq) |-> (blk != 9'd0 && blk <= MAX_M));

  // R11: diagnostic ends quiet with the pass code
  assert_diag_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_state && cmd_q == OP_DIAG && !cmd_accept) |=> (err_reg == DIAG_PASS && !bsy && !drq));

  // R10: an opcode outside the supported set aborts
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_state && !cmd_accept && cmd_q != OP_DIAG && cmd_q != OP_SET_MULT &&
     cmd_q != OP_READ_SECT && cmd_q != OP_READ_MULT)
    |=> (err_flag && err_reg == ERR_ABORT && !bsy && !drq));

  // R6: the final word leaves the sequencer idle
  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_finish && !cmd_accept) |=> (!bsy && !drq));

endmodule

// File: rtl/ata_irq_ctl.sv
module ata_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_set,
  input  logic cmd_accept,
  input  logic stat_rd,
  input  logic alt_rd,
  input  logic nien,
  output logic pending,
  output logic intrq
);

  always_ff @(posedge clk) begin
    if (!rst_n)          pending <= 1'b0;
    else if (cmd_accept) pending <= 1'b0;
    else if (irq_set)    pending <= 1'b1;
    else if (stat_rd)    pending <= 1'b0;
  end

  assign intrq = pending && !nien;

  // R3: a status read with no new event clears the interrupt
  assert_stat_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_set && !cmd_accept) |=> !pending);

  // R4: an alternate status read keeps the interrupt
  assert_alt_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_rd && pending && !stat_rd && !cmd_accept) |=> pending);

endmodule

// File: rtl/ata_taskfile_seq.sv
module ata_taskfile_seq
  import ata_seq_pkg::*;
#(
  parameter int WORDS_PER_SECTOR = 256,
  parameter int MAX_MULT         = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic        host_ctl,
  input  logic [2:0]  host_reg,
  input  logic [7:0]  host_wdata,
  output logic [15:0] host_rdata,
  output logic        intrq,
  output logic        sec_req,
  input  logic        sec_rdy
);

  localparam int IDX_W = $clog2(WORDS_PER_SECTOR);

  logic [7:0] scnt_q, snum_q, cyll_q, cylh_q, devh_q, cmd_code, err_reg, sec_ord, status;
  logic       nien_q, cmd_wr, bsy, drq, err_flag, irq_set, cmd_accept, pending;
  logic       stat_rd, alt_rd, data_rd;
  logic [IDX_W-1:0] word_idx;
  logic [15:0] data_word;

  assign stat_rd   = host_rd && !host_ctl && (host_reg == REG_CMD);
  assign alt_rd    = host_rd && host_ctl && (host_reg == REG_ALT);
  assign data_rd   = host_rd && !host_ctl && (host_reg == REG_DATA);
  assign status    = status_byte(bsy, drq, err_flag);
  assign data_word = word_pattern(snum_q, sec_ord, 16'(word_idx));

  ata_tf_regs i_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_ctl(host_ctl),
    .host_reg(host_reg), .host_wdata(host_wdata), .busy(bsy || drq),
    .scnt_q(scnt_q), .snum_q(snum_q), .cyll_q(cyll_q), .cylh_q(cylh_q),
    .devh_q(devh_q), .nien_q(nien_q), .cmd_wr(cmd_wr), .cmd_code(cmd_code)
  );

  ata_seq_fsm #(.WORDS_PER_SECTOR(WORDS_PER_SECTOR), .MAX_MULT(MAX_MULT)) i_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code), .scnt(scnt_q),
    .sec_rdy(sec_rdy), .data_rd(data_rd), .bsy(bsy), .drq(drq), .err_flag(err_flag),
    .err_reg(err_reg), .sec_req(sec_req), .irq_set(irq_set), .cmd_accept(cmd_accept),
    .sec_ord(sec_ord), .word_idx(word_idx)
  );

  ata_irq_ctl i_irq (
    .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .cmd_accept(cmd_accept),
    .stat_rd(stat_rd), .alt_rd(alt_rd), .nien(nien_q), .pending(pending), .intrq(intrq)
  );

  always_comb begin
    host_rdata = 16'h0000;
    if (host_ctl) begin
      if (host_reg == REG_ALT) host_rdata = {8'h00, status};
    end else begin
      case (host_reg)
        REG_DATA: host_rdata = drq ? data_word : 16'h0000;
        REG_ERR:  host_rdata = {8'h00, err_reg};
        REG_SCNT: host_rdata = {8'h00, scnt_q};
        REG_SNUM: host_rdata = {8'h00, snum_q};
        REG_CYLL: host_rdata = {8'h00, cyll_q};
        REG_CYLH: host_rdata = {8'h00, cylh_q};
        REG_DEVH: host_rdata = {8'h00, devh_q};
        default:  host_rdata = {8'h00, status};
      endcase
    end
  end

endmodule

// File: tb/test_ata_taskfile_seq.sv
`timescale 1ns/1ps
module test_ata_taskfile_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_ctl = 1'b0;
  logic [2:0]  host_reg = 3'd0;
  logic [7:0]  host_wdata = 8'h00;
  logic [15:0] host_rdata;
  logic        intrq, sec_req;
  logic        sec_rdy = 1'b0;
  bit          media_en = 1'b1;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ata_taskfile_seq i_ata_taskfile_seq (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_ctl(host_ctl),
    .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .intrq(intrq), .sec_req(sec_req), .sec_rdy(sec_rdy)
  );

  function automatic logic [15:0] expect_word(logic [7:0] sn, int k, int w);
    logic [7:0] hi;
    hi = sn + 8'(k);
    return {hi, 8'(w)};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic ctl, input logic [2:0] r, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_ctl = ctl; host_reg = r; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic ctl, input logic [2:0] r, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_ctl = ctl; host_reg = r;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!intrq && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (!intrq) chk(tag, 0, 1);
  endtask

  // after the command write: block-by-block checking of a data-in command
  task automatic read_body(input bit multi, input int cnt, input logic [7:0] sn,
                           input int mult, input bit inject);
    logic [15:0] v;
    int rem = cnt, k = 0, b, mism;
    bit irq_seen;
    while (rem > 0) begin
      b = multi ? ((rem < mult) ? rem : mult) : 1;
      wait_irq("R5 block interrupt");
      rd_reg(1'b1, 3'd6, v); chk("R5 data-request status", v, 16'h0058);
      rd_reg(1'b1, 3'd6, v); chk("R4 alternate read keeps intrq", intrq, 1);
      rd_reg(1'b0, 3'd7, v); chk("R3 status read clears intrq", intrq, 0);
      mism = 0; irq_seen = 0;
      for (int s = 0; s < b; s++) begin
        for (int w = 0; w < 256; w++) begin
          if (inject && k == 0 && w == 10) begin
            wr_reg(1'b0, 3'd7, 8'h20);
            wr_reg(1'b0, 3'd2, 8'h09);
            rd_reg(1'b1, 3'd6, v); chk("R12 busy command ignored", v, 16'h0058);
          end
          rd_reg(1'b0, 3'd0, v);
          if (v !== expect_word(sn, k, w)) mism++;
          if (intrq) irq_seen = 1;
        end
        k++;
      end
      chk(multi ? "R8 block data" : "R5 sector data", mism, 0);
      if (multi) chk("R8 no interrupt inside block", irq_seen, 0);
      rem -= b;
    end
    rd_reg(1'b1, 3'd6, v); chk("R6 final status", v, 16'h0050);
    chk("R6 no final interrupt", intrq, 0);
  endtask

  task automatic run_read(input bit multi, input int cnt, input logic [7:0] sn, input int mult);
    wr_reg(1'b0, 3'd2, 8'(cnt));
    wr_reg(1'b0, 3'd3, sn);
    wr_reg(1'b0, 3'd7, multi ? 8'hC4 : 8'h20);
    read_body(multi, cnt, sn, mult, 1'b0);
  endtask

  task automatic expect_done(input string tag, input logic [15:0] st, input logic [15:0] er);
    logic [15:0] v;
    wait_irq(tag);
    rd_reg(1'b1, 3'd6, v); chk(tag, v, st);
    rd_reg(1'b0, 3'd1, v); chk(tag, v, er);
    rd_reg(1'b0, 3'd7, v);
  endtask

  // media stand-in: answers each request after a random delay
  initial begin
    forever begin
      @(negedge clk);
      if (sec_req && media_en && rst_n) begin
        repeat ($urandom_range(0, 15)) @(negedge clk);
        sec_rdy = 1'b1;
        @(negedge clk);
        sec_rdy = 1'b0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int cnt, mult;
    bit multi;
    logic [7:0] sn;
    void'($urandom(32'h0A7A_51D3));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(1'b1, 3'd6, v); chk("R1 reset status", v, 16'h0050);
    rd_reg(1'b0, 3'd1, v); chk("R1 reset error code", v, 16'h0001);
    chk("R1 reset intrq", intrq, 0);

    // R9 blocked read without block size
    wr_reg(1'b0, 3'd7, 8'hC4);
    expect_done("R9 blocked read aborts", 16'h0051, 16'h0004);

    // R10 unsupported opcode
    wr_reg(1'b0, 3'd7, 8'hEC);
    expect_done("R10 unsupported opcode", 16'h0051, 16'h0004);

    // R7 block size setting
    wr_reg(1'b0, 3'd2, 8'd3);  wr_reg(1'b0, 3'd7, 8'hC6);
    expect_done("R7 non power of two aborts", 16'h0051, 16'h0004);
    wr_reg(1'b0, 3'd2, 8'd4);  wr_reg(1'b0, 3'd7, 8'hC6);
    expect_done("R7 valid size accepted", 16'h0050, 16'h0000);
    wr_reg(1'b0, 3'd2, 8'd32); wr_reg(1'b0, 3'd7, 8'hC6);
    expect_done("R7 oversize aborts", 16'h0051, 16'h0004);
    run_read(1'b1, 6, 8'h30, 4);   // R8: blocks of 4 and 2, size kept after rejection

    // R2 busy while media is silent
    media_en = 0;
    wr_reg(1'b0, 3'd2, 8'd1); wr_reg(1'b0, 3'd3, 8'h05); wr_reg(1'b0, 3'd7, 8'h20);
    rd_reg(1'b1, 3'd6, v); chk("R2 busy after command", v, 16'h00D0);
    repeat (20) @(negedge clk);
    rd_reg(1'b1, 3'd6, v); chk("R2 busy while waiting", v, 16'h00D0);
    chk("R2 sector request held", sec_req, 1);
    media_en = 1;
    read_body(1'b0, 1, 8'h05, 1, 1'b0);

    // R12 commands and task-file writes ignored during transfer
    wr_reg(1'b0, 3'd2, 8'd2); wr_reg(1'b0, 3'd3, 8'h40); wr_reg(1'b0, 3'd7, 8'h20);
    read_body(1'b0, 2, 8'h40, 1, 1'b1);
    rd_reg(1'b0, 3'd2, v); chk("R12 sector count unchanged", v, 16'h0002);

    // R11 diagnostic breaks into a transfer
    wr_reg(1'b0, 3'd2, 8'd3); wr_reg(1'b0, 3'd3, 8'h00); wr_reg(1'b0, 3'd7, 8'h20);
    wait_irq("R11 first sector");
    rd_reg(1'b0, 3'd7, v);
    for (int i = 0; i < 5; i++) rd_reg(1'b0, 3'd0, v);
    wr_reg(1'b0, 3'd7, 8'h90);
    expect_done("R11 diagnostic result", 16'h0050, 16'h0001);
    repeat (30) @(negedge clk);
    chk("R11 no further request", sec_req, 0);
    rd_reg(1'b0, 3'd0, v); chk("R11 transfer ended", v, 16'h0000);

    // R13 interrupt mask
    wr_reg(1'b1, 3'd6, 8'h02);
    wr_reg(1'b0, 3'd7, 8'h90);
    repeat (10) @(negedge clk);
    chk("R13 masked pin low", intrq, 0);
    rd_reg(1'b1, 3'd6, v); chk("R13 status while masked", v, 16'h0050);
    wr_reg(1'b1, 3'd6, 8'h00);
    chk("R13 pending shows after unmask", intrq, 1);
    rd_reg(1'b0, 3'd7, v); chk("R13 cleared by status read", intrq, 0);

    // random mix of sector and blocked reads
    for (int it = 0; it < 10; it++) begin
      multi = 1'($urandom_range(0, 1));
      cnt   = $urandom_range(1, 6);
      sn    = 8'($urandom);
      mult  = 1 << $urandom_range(0, 3);
      if (multi) begin
        wr_reg(1'b0, 3'd2, 8'(mult)); wr_reg(1'b0, 3'd7, 8'hC6);
        expect_done("R7 random size", 16'h0050, 16'h0000);
      end
      run_read(multi, cnt, sn, mult);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule